// File: doc/BRIEF.md
# Eight-Channel TDM Serial Audio Receiver

This block turns one frame-synchronous serial audio line into parallel samples. A pulse on the frame-sync input opens a frame. Eight words then follow back to back on the data line, one for each of four stereo pairs, each pair sent left then right. Every word is sent most significant bit first, and all words have the same configured length. Whatever the line carries after the eighth word, until the next frame-sync pulse, is discarded.

Everything runs on the bit clock. Frame sync and data are both sampled on its rising edge. As each word completes, the block presents that word sign-extended to 32 bits, together with its channel index and a one-cycle valid strobe. The last channel of a frame also raises an end-of-frame strobe. A frame-sync pulse that arrives before the frame is complete is treated as an error. The unfinished word is thrown away, a sticky error flag is raised, and reception starts again from channel 0.

Top module: `tdm8_rx`

## Requirements
- R1: After an active-low reset, valid, end-of-frame, channel, sample and the error flag are all zero. No word is output until a frame-sync rising edge has been seen, whatever the data line does.
- R2: A frame-sync rising edge is detected at the bit-clock edge where fsync is sampled high after having been sampled low. The data bit at that same edge is ignored, and the first word's MSB is sampled on the following edge.
- R3: Words are indexed 0 to 7 in arrival order: pair 1 left = 0, pair 1 right = 1, and so on up to pair 4 right = 7.
- R4: Words are contiguous. With the frame-sync rising edge at bit-clock edge E and word length n, word k (0-based) has its LSB at edge E+(k+1)·n, and its valid strobe is visible in the cycle that follows that edge.
- R5: Each word is assembled MSB first and output on sample_o sign-extended from bit n-1 to 32 bits.
- R6: wlen_sel selects the word length: 0 gives 16 bits, 1 gives 20, 2 gives 24 and 3 gives 32. The value is captured at the frame-sync rising edge, and changes during a frame have no effect on that frame.
- R7: Bits that follow the eighth word's LSB, up to the next frame-sync rising edge, produce no output. Exactly eight words are output per complete frame.
- R8: valid_o is high for one cycle per word. eof_o is high only together with valid_o for channel 7.
- R9: A frame-sync rising edge that arrives before channel 7 has completed sets frame_err_o. The word in progress is dropped without output, and the new frame starts at channel 0.
- R10: Once set, frame_err_o stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all sampling on its rising edge |
| rst_n | input | 1 | Active-low reset |
| fsync | input | 1 | Frame-sync pulse; its rising edge opens a frame |
| sdata | input | 1 | Serial data, MSB first |
| wlen_sel | input | 2 | Word length code (0:16, 1:20, 2:24, 3:32) |
| sample_o | output | 32 | Completed word, sign-extended |
| chan_o | output | 3 | Channel index of sample_o |
| valid_o | output | 1 | One-cycle strobe per completed word |
| eof_o | output | 1 | Strobe with the last channel of a frame |
| frame_err_o | output | 1 | Sticky early frame-sync flag |

## Verification
All four word lengths are driven with frames of all ones, alternating bits, hashed values and sparse single bits. This separates sign-extension errors from bit-order errors and off-by-one shift counts. Idle tails of zero, one and several bits, with live toggling data, show whether the receiver locks onto trailing garbage or misses a back-to-back frame. A frame whose length code changes mid-frame shows that the code is captured only at the frame edge. Truncated frames are also driven: one after a single bit, one mid-word, and one missing only its final LSB. They tell a correct drop-and-restart apart from a leaked partial word or a stale channel index.

// File: rtl/tdm8_pkg.sv
package tdm8_pkg;

  localparam int SAMPLE_W = 32;
  localparam int LEN_W    = 6;

  // word length code to bit count
  function automatic logic [LEN_W-1:0] wlen_bits(input logic [1:0] sel);
    logic [LEN_W-1:0] r;
    case (sel)
      2'd0:    r = 6'd16;
      2'd1:    r = 6'd20;
      2'd2:    r = 6'd24;
      default: r = 6'd32;
    endcase
    return r;
  endfunction

  // sign-extend the low n bits of raw to the full sample width
  function automatic logic [SAMPLE_W-1:0] sext_word(input logic [SAMPLE_W-1:0] raw,
                                                    input logic [LEN_W-1:0] n);
    logic [LEN_W-1:0] sh;
    logic [SAMPLE_W-1:0] up;
    sh = 6'(6'd32 - n);
    up = raw << sh;
    return $unsigned($signed(up) >>> sh);
  endfunction

endpackage

// File: rtl/tdm8_edge.sv
module tdm8_edge (
  input  logic bclk,
  input  logic rst_n,
  input  logic fsync,
  output logic frame_start
);

  logic fs_q;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) fs_q <= 1'b0;
    else        fs_q <= fsync;
  end

  assign frame_start = fsync & ~fs_q;

  // R2: a detected edge cannot repeat on the next bit clock
  assert_start_single_R2: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_start |=> !frame_start);

endmodule

// File: rtl/tdm8_framer.sv
module tdm8_framer #(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic                      bclk,
  input  logic                      rst_n,
  input  logic                      frame_start,
  input  logic [1:0]                wlen_sel,
  output logic                      active,
  output logic                      word_done,
  output logic                      last_word,
  output logic                      early_sync,
  output logic [CH_W-1:0]           chan,
  output logic [tdm8_pkg::LEN_W-1:0] cur_len
);
  import tdm8_pkg::*;

  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  logic             active_q;
  logic [LEN_W-1:0] bit_q;
  logic [LEN_W-1:0] len_q;
  logic [CH_W-1:0]  chan_q;
  logic             at_lsb;

  assign at_lsb = (bit_q == 6'(len_q - 6'd1));

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      bit_q    <= '0;
      chan_q   <= '0;
      len_q    <= wlen_bits(2'd0);
    end else if (frame_start) begin
      active_q <= 1'b1;
      bit_q    <= '0;
      chan_q   <= '0;
      len_q    <= wlen_bits(wlen_sel);
    end else if (active_q) begin
      if (at_lsb) begin
        bit_q <= '0;
        if (chan_q == LAST_CH) begin
          active_q <= 1'b0;
          chan_q   <= '0;
        end else begin
          chan_q <= CH_W'(chan_q + 1'b1);
        end
      end else begin
        bit_q <= 6'(bit_q + 6'd1);
      end
    end
  end

  assign active     = active_q;
  assign word_done  = active_q && !frame_start && at_lsb;
  assign last_word  = (chan_q == LAST_CH);
  assign early_sync = frame_start && active_q;
  assign chan       = chan_q;
  assign cur_len    = len_q;

  // R4: bit position stays inside the latched word
  assert_bit_in_word_R4: assert property (@(posedge bclk) disable iff (!rst_n)
    active_q |-> (bit_q < len_q));

  // R3: channels advance by one per completed word
  assert_chan_step_R3: assert property (@(posedge bclk) disable iff (!rst_n)
    (word_done && chan_q != LAST_CH) |=> (chan_q == CH_W'($past(chan_q) + 1'b1)));

  // R7: reception only ends after the last channel's LSB
  assert_end_after_last_R7: assert property (@(posedge bclk) disable iff (!rst_n)
    $fell(active_q) |-> $past(chan_q == LAST_CH && at_lsb));

  // R6: word length held throughout a frame
  assert_len_hold_R6: assert property (@(posedge bclk) disable iff (!rst_n)
    (active_q && !frame_start) |=> (len_q == $past(len_q)));

endmodule

// File: rtl/tdm8_shifter.sv
module tdm8_shifter (
  input  logic                           bclk,
  input  logic                           rst_n,
  input  logic                           shift_en,
  input  logic                           sdata,
  output logic [tdm8_pkg::SAMPLE_W-1:0]  raw_word
);
  import tdm8_pkg::*;

  logic [SAMPLE_W-1:0] sh_q;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n)        sh_q <= '0;
    else if (shift_en) sh_q <= {sh_q[SAMPLE_W-2:0], sdata};
  end

  // word including the bit being sampled now
  assign raw_word = {sh_q[SAMPLE_W-2:0], sdata};

endmodule

// File: rtl/tdm8_rx.sv
module tdm8_rx #(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic            bclk,
  input  logic            rst_n,
  input  logic            fsync,
  input  logic            sdata,
  input  logic [1:0]      wlen_sel,
  output logic [31:0]     sample_o,
  output logic [CH_W-1:0] chan_o,
  output logic            valid_o,
  output logic            eof_o,
  output logic            frame_err_o
);
  import tdm8_pkg::*;

  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  logic                frame_start;
  logic                rx_active;
  logic                word_done;
  logic                last_word;
  logic                early_sync;
  logic [CH_W-1:0]     cur_chan;
  logic [LEN_W-1:0]    cur_len;
  logic [SAMPLE_W-1:0] raw_word;
  logic                shift_en;

  tdm8_edge u_edge (
    .bclk        (bclk),
    .rst_n       (rst_n),
    .fsync       (fsync),
    .frame_start (frame_start)
  );

  tdm8_framer #(.NUM_CH(NUM_CH)) u_framer (
    .bclk        (bclk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .wlen_sel    (wlen_sel),
    .active      (rx_active),
    .word_done   (word_done),
    .last_word   (last_word),
    .early_sync  (early_sync),
    .chan        (cur_chan),
    .cur_len     (cur_len)
  );

  assign shift_en = rx_active && !frame_start;

  tdm8_shifter u_shift (
    .bclk     (bclk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .sdata    (sdata),
    .raw_word (raw_word)
  );

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      sample_o    <= '0;
      chan_o      <= '0;
      valid_o     <= 1'b0;
      eof_o       <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      valid_o <= word_done;
      eof_o   <= word_done && last_word;
      if (word_done) begin
        sample_o <= sext_word(raw_word, cur_len);
        chan_o   <= cur_chan;
      end
      if (early_sync) frame_err_o <= 1'b1;
    end
  end

  // upper bits above the word's sign bit must all agree with it
  logic [31:0] sign_span;
  logic        sign_ok;
  assign sign_span = $unsigned($signed(sample_o) >>> 6'(cur_len - 6'd1));
  assign sign_ok   = (sign_span == '0) || (sign_span == '1);

  // R8: valid is a single-cycle strobe
  assert_valid_pulse_R8: assert property (@(posedge bclk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R8: end-of-frame only with the last channel's word
  assert_eof_last_R8: assert property (@(posedge bclk) disable iff (!rst_n)
    eof_o |-> (valid_o && chan_o == LAST_CH));

  // R10: error flag is sticky
  assert_err_sticky_R10: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_err_o |=> frame_err_o);

  // R5: output is properly sign-extended
  assert_sign_ext_R5: assert property (@(posedge bclk) disable iff (!rst_n)
    valid_o |-> sign_ok);

  // R1/R7: words only come out of an active frame
  assert_valid_in_frame_R7: assert property (@(posedge bclk) disable iff (!rst_n)
    valid_o |-> $past(rx_active));

endmodule

// File: tb/tdm8_rx_tb.sv
module tdm8_rx_tb;

  logic        clk;
  logic        rst_n;
  logic        fsync;
  logic        sdata;
  logic [1:0]  wlen_sel;
  logic [31:0] sample_o;
  logic [2:0]  chan_o;
  logic        valid_o;
  logic        eof_o;
  logic        frame_err_o;

  tdm8_rx #(.NUM_CH(8)) u_dut (
    .bclk        (clk),
    .rst_n       (rst_n),
    .fsync       (fsync),
    .sdata       (sdata),
    .wlen_sel    (wlen_sel),
    .sample_o    (sample_o),
    .chan_o      (chan_o),
    .valid_o     (valid_o),
    .eof_o       (eof_o),
    .frame_err_o (frame_err_o)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // output records
  int          rec_cnt = 0;
  int          rec_cyc [1024];
  logic [31:0] rec_dat [1024];
  logic [2:0]  rec_ch  [1024];
  logic        rec_eof [1024];
  int          eof_alone = 0;
  int          valid_runs = 0;
  logic        prev_valid = 1'b0;

  always @(posedge clk) begin
    #1;
    if (valid_o && rec_cnt < 1024) begin
      rec_cyc[rec_cnt] = cyc;
      rec_dat[rec_cnt] = sample_o;
      rec_ch[rec_cnt]  = chan_o;
      rec_eof[rec_cnt] = eof_o;
      rec_cnt++;
    end
    if (eof_o && !valid_o) eof_alone++;
    if (valid_o && prev_valid) valid_runs++;
    prev_valid = valid_o;
  end

  // frame descriptors
  int fr_E    [64];
  int fr_len  [64];
  int fr_seed [64];
  int fr_nw   [64];
  bit fr_chg  [64];
  int nf = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wl(input logic [1:0] s);
    return (s == 2'd3) ? 32 : 16 + 4 * int'(s);
  endfunction

  function automatic logic [31:0] pat(input int s, input int k);
    logic [31:0] v;
    case (s % 4)
      0: v = 32'hFFFF_FFFF;
      1: v = k[0] ? 32'hAAAA_AAAA : 32'h5555_5555;
      2: v = (32'(s) * 32'h9E37_79B1) ^ (32'(k + 1) * 32'h85EB_CA6B);
      default: v = 32'h1 << ((k * 5 + s) % 32);
    endcase
    return v;
  endfunction

  function automatic logic [31:0] expect_word(input int s, input int k, input int n);
    logic [31:0] mask;
    logic [31:0] v;
    mask = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    v = pat(s, k) & mask;
    if (v[n-1]) v = v | ~mask;
    return v;
  endfunction

  task automatic send_frame(input logic [1:0] sel, input int seed, input int nw,
                            input int extra, input int tail, input bit chg,
                            input logic [1:0] sel_mid);
    int n;
    int tot;
    logic [31:0] v;
    n = wl(sel);
    tot = nw + ((extra > 0) ? 1 : 0);
    @(negedge clk);
    wlen_sel = sel;
    fsync = 1'b1;
    sdata = 1'b1;                  // R2: bit at the edge cycle must be ignored
    fr_E[nf] = cyc + 1;
    fr_len[nf] = n;
    fr_seed[nf] = seed;
    fr_nw[nf] = nw;
    fr_chg[nf] = chg;
    nf++;
    for (int k = 0; k < tot; k++) begin
      int bits;
      bits = (k < nw) ? n : extra;
      v = pat(seed, k);
      for (int b = 0; b < bits; b++) begin
        @(negedge clk);
        fsync = 1'b0;
        if (chg && k == 2 && b == 0) wlen_sel = sel_mid;
        sdata = v[n-1-b];
      end
    end
    for (int t = 0; t < tail; t++) begin
      @(negedge clk);
      fsync = 1'b0;
      sdata = ~t[0];               // R7: live garbage in the tail
    end
  endtask

  task automatic check_all();
    for (int i = 0; i < nf; i++) begin
      int lo;
      int hi;
      int n;
      int cnt;
      n = fr_len[i];
      lo = fr_E[i];
      hi = (i + 1 < nf) ? fr_E[i+1] : fr_E[i] + 8 * n;
      cnt = 0;
      for (int r = 0; r < rec_cnt; r++)
        if (rec_cyc[r] > lo && rec_cyc[r] <= hi) cnt++;
      // R7: exactly eight words per full frame; R9: partial word dropped
      chk(cnt == fr_nw[i], (fr_nw[i] < 8) ? "R9 word count" : "R7 word count",
          32'(cnt), 32'(fr_nw[i]));
      for (int k = 0; k < fr_nw[i]; k++) begin
        int tgt;
        int idx;
        logic [31:0] ex;
        bit ok;
        tgt = fr_E[i] + (k + 1) * n;   // R4: contiguous word timing
        idx = -1;
        for (int r = 0; r < rec_cnt; r++)
          if (rec_cyc[r] == tgt) idx = r;
        ex = expect_word(fr_seed[i], k, n);
        if (idx < 0) begin
          chk(1'b0, "R4 word timing", 32'(k), 32'(tgt));
        end else begin
          // R2 first MSB, R3 channel order, R5 data, R8 eof
          ok = (rec_ch[idx] == 3'(k)) && (rec_dat[idx] == ex) && (rec_eof[idx] == (k == 7));
          if (fr_chg[i])
            chk(ok, "R6 latched length", rec_dat[idx], ex);
          else if (rec_ch[idx] != 3'(k))
            chk(ok, "R3 channel", 32'(rec_ch[idx]), 32'(k));
          else if (rec_eof[idx] != (k == 7))
            chk(ok, "R8 eof", 32'(rec_eof[idx]), 32'(k == 7));
          else
            chk(ok, "R5 word data", rec_dat[idx], ex);
        end
      end
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    fsync = 1'b0;
    sdata = 1'b0;
    wlen_sel = 2'd0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(valid_o == 1'b0 && eof_o == 1'b0, "R1 reset strobes", {30'd0, valid_o, eof_o}, 32'd0);
    chk(sample_o == 32'd0 && chan_o == 3'd0, "R1 reset data", sample_o, 32'd0);
    chk(frame_err_o == 1'b0, "R1 reset error", 32'(frame_err_o), 32'd0);
    rst_n = 1'b1;

    // R1: data without any frame sync gives no words
    for (int t = 0; t < 60; t++) begin
      @(negedge clk);
      sdata = t[1] ^ t[0];
    end
    chk(rec_cnt == 0, "R1 no sync no words", 32'(rec_cnt), 32'd0);

    // R6: all word lengths, several patterns and tails
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 4; p++) begin
        send_frame(2'(s), s * 4 + p, 8, 0, (p == 0) ? 0 : p * 3, 1'b0, 2'd0);
      end
    end
    // R6: length code changed mid-frame is ignored
    send_frame(2'd1, 18, 8, 0, 4, 1'b1, 2'd3);
    send_frame(2'd2, 6, 8, 0, 2, 1'b0, 2'd0);
    repeat (3) @(negedge clk);
    chk(frame_err_o == 1'b0, "R9 no error on clean frames", 32'(frame_err_o), 32'd0);

    // R9: early frame sync cases
    send_frame(2'd2, 22, 3, 5, 0, 1'b0, 2'd0);
    send_frame(2'd0, 2, 8, 0, 2, 1'b0, 2'd0);
    send_frame(2'd0, 3, 0, 1, 0, 1'b0, 2'd0);
    send_frame(2'd3, 14, 8, 0, 1, 1'b0, 2'd0);
    send_frame(2'd0, 10, 7, 15, 0, 1'b0, 2'd0);
    send_frame(2'd1, 5, 8, 0, 6, 1'b0, 2'd0);
    repeat (6) @(negedge clk);

    check_all();
    // R10: error remains set through later clean frames
    chk(frame_err_o == 1'b1, "R10 sticky error", 32'(frame_err_o), 32'd1);
    chk(eof_alone == 0, "R8 eof without valid", 32'(eof_alone), 32'd0);
    chk(valid_runs == 0, "R8 valid longer than one cycle", 32'(valid_runs), 32'd0);
    finish_run();
  end

endmodule